// File: doc/BRIEF.md
# Register/Memory Move Field Decoder

This block decodes register/memory move instructions from a byte stream that arrives one byte per clock, qualified by a valid strobe. Bytes with the strobe low are skipped. A static input selects the default operating mode, 16-bit or 32-bit. Ahead of the opcode, the stream may carry two kinds of size-override prefix: one flips the wide operand size and the other flips the address size. Each prefix applies to the current instruction only.

After the opcode, the decoder captures the addressing byte. From the mode field, the register-or-memory field and the effective address size, it works out how many displacement bytes follow, then collects them. One clock after the final byte of the instruction is accepted, it presents a registered record for one cycle. The record gives the decoded sizes, the direction, the width, the three fields of the addressing byte, a displacement widened to 32 bits and the total byte count. An opcode outside the four register/memory move forms, or a form that would need a scale-index byte, gives a record with the unsupported flag set.

Top module: `movdec_top`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rec_valid_o` is 0 and every record output is 0.
- R2: `op32_o` equals `mode32_i` inverted when one or more 66h bytes preceded the opcode. `addr32_o` equals `mode32_i` inverted when one or more 67h bytes preceded it. Repeats of a prefix count as one, and prefix state is cleared after each record.
- R3: For opcodes 88h to 8Bh, `dir_o` is opcode bit 1 and `wide_o` is opcode bit 0. `opnd_bits_o` is 8 when bit 0 is 0, whatever the prefixes, and otherwise 32 or 16 according to `op32_o`.
- R4: The byte after the opcode is split as mode in bits 7:6 (`mod_o`), register in bits 5:3 (`reg_o`) and register-or-memory in bits 2:0 (`rm_o`).
- R5: The number of displacement bytes collected depends on the mode and the effective address size:
  - mode 11 and mode 00 take none, with two exceptions: mode 00 with rm 110 under 16-bit addressing takes 2, and mode 00 with rm 101 under 32-bit addressing takes 4;
  - mode 01 takes 1;
  - mode 10 takes 2 under 16-bit addressing and 4 under 32-bit addressing.
  No record appears before the last of these bytes.
- R6: Displacement bytes arrive least significant first. `disp_o` holds the 1-byte or 2-byte value sign-extended to 32 bits, the 4-byte value unchanged, or 0 when no displacement bytes are taken.
- R7: `len_o` counts every prefix, the opcode, the addressing byte and the displacement bytes, and saturates at 15.
- R8: Any opcode byte that is neither a prefix nor 88h to 8Bh gives a record one cycle later. In that record `unsup_o` is 1, `len_o` counts the prefixes plus the opcode, `op32_o` and `addr32_o` follow R2, and every other field is 0.
- R9: Under 32-bit addressing, a mode other than 11 with rm 100 gives an unsupported record one cycle after the addressing byte. No displacement bytes are collected, `len_o` counts the prefixes plus 2, and the remaining fields are 0 as in R8.
- R10: `rec_valid_o` is a single-cycle pulse in the cycle after the final byte of an instruction is accepted. The record fields hold their values until the next record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode32_i | input | 1 | Default mode: 1 = 32-bit, 0 = 16-bit; held stable during an instruction |
| byte_valid_i | input | 1 | Qualifies `byte_i` |
| byte_i | input | 8 | Instruction stream byte |
| rec_valid_o | output | 1 | Record strobe |
| unsup_o | output | 1 | Unsupported opcode or addressing form |
| op32_o | output | 1 | Effective operand size is 32 bits |
| addr32_o | output | 1 | Effective address size is 32 bits |
| dir_o | output | 1 | 1: register-or-memory operand to register field |
| wide_o | output | 1 | Width bit of the opcode |
| opnd_bits_o | output | 6 | Operand width in bits (8, 16 or 32) |
| mod_o | output | 2 | Mode field |
| reg_o | output | 3 | Register field |
| rm_o | output | 3 | Register-or-memory field |
| disp_o | output | 32 | Sign-extended displacement |
| len_o | output | 4 | Instruction length in bytes |

## Verification
A corrupted sequencer state or a stale displacement count shows up at the ports at once. The record comes one byte early or late, or is missing, and the cycle-exact strobe check catches that within the instruction where it goes wrong. A prefix flag that fails to clear shows up as a wrong size on the next instruction's record. A bad byte lane in the displacement register shows in `disp_o` of the first record that uses that lane. The sweep covers every mode, every register-or-memory value, every move opcode, both default modes and every prefix combination, so each such fault is seen within a few hundred cycles.

// File: rtl/movdec_pkg.sv
package movdec_pkg;
  localparam logic [7:0] PFX_OPSZ   = 8'h66;
  localparam logic [7:0] PFX_ADSZ   = 8'h67;
  localparam logic [5:0] MOV_RM_TAG = 6'b100010;

  typedef enum logic [1:0] {ST_PREFIX, ST_MODRM, ST_DISP} dec_state_e;

  typedef struct packed {
    logic [1:0] mode;
    logic [2:0] regf;
    logic [2:0] rmf;
  } addr_byte_t;
endpackage

// File: rtl/movdec_dispsize.sv
module movdec_dispsize
  import movdec_pkg::*;
(
  input  addr_byte_t ab_i,
  input  logic       addr32_i,
  output logic [2:0] nbytes_o,
  output logic       sib_bad_o
);
  always_comb begin
    nbytes_o  = 3'd0;
    sib_bad_o = addr32_i && (ab_i.mode != 2'b11) && (ab_i.rmf == 3'b100);
    case (ab_i.mode)
      2'b00: begin
        if (addr32_i && ab_i.rmf == 3'b101)       nbytes_o = 3'd4;
        else if (!addr32_i && ab_i.rmf == 3'b110) nbytes_o = 3'd2;
      end
      2'b01:   nbytes_o = 3'd1;
      2'b10:   nbytes_o = addr32_i ? 3'd4 : 3'd2;
      default: nbytes_o = 3'd0;
    endcase
  end
endmodule

// File: rtl/movdec_disp_acc.sv
module movdec_disp_acc #(
  parameter int LANES = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int DW = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       din_i,
  input  logic [2:0]       nbytes_i,
  output logic [DW-1:0]    disp_o
);
  logic [7:0]    lane_q [LANES];
  logic [DW-1:0] merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
    end else if (wr_i) begin
      for (int i = 0; i < LANES; i++)
        if (idx_i == IDX_W'(i)) lane_q[i] <= din_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*8 +: 8] = (wr_i && idx_i == IDX_W'(g)) ? din_i : lane_q[g];
  end

  always_comb begin
    case (nbytes_i)
      3'd1:    disp_o = {{(DW-8){merged[7]}}, merged[7:0]};
      3'd2:    disp_o = {{(DW-16){merged[15]}}, merged[15:0]};
      default: disp_o = merged;
    endcase
  end
endmodule

// File: rtl/movdec_len_ctr.sv
module movdec_len_ctr #(
  parameter int W = 4,
  localparam logic [W-1:0] MAXV = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] next_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
  end

  assign next_o = (cnt_q == MAXV) ? MAXV : cnt_q + 1'b1;
endmodule

// File: rtl/movdec_top.sv
module movdec_top
  import movdec_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int DISP_LANES = 4,
  localparam int IDX_W = (DISP_LANES > 1) ? $clog2(DISP_LANES) : 1,
  localparam int DW = 8 * DISP_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode32_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic             rec_valid_o,
  output logic             unsup_o,
  output logic             op32_o,
  output logic             addr32_o,
  output logic             dir_o,
  output logic             wide_o,
  output logic [5:0]       opnd_bits_o,
  output logic [1:0]       mod_o,
  output logic [2:0]       reg_o,
  output logic [2:0]       rm_o,
  output logic [DW-1:0]    disp_o,
  output logic [LEN_W-1:0] len_o
);
  dec_state_e       state_q;
  logic             opsz_q, adsz_q, dir_q, wide_q;
  addr_byte_t       ab_q;
  logic [2:0]       nb_q;
  logic [IDX_W-1:0] didx_q;

  addr_byte_t       ab_in;
  logic             op32_eff, addr32_eff;
  logic [2:0]       nb_new;
  logic             sib_bad;
  logic             is_pfx, is_mov, emit, unsup_n, last_disp;
  logic [DW-1:0]    disp_ext;
  logic [LEN_W-1:0] len_next;

  assign ab_in      = addr_byte_t'(byte_i);
  assign op32_eff   = mode32_i ^ opsz_q;
  assign addr32_eff = mode32_i ^ adsz_q;
  assign is_pfx     = (byte_i == PFX_OPSZ) || (byte_i == PFX_ADSZ);
  assign is_mov     = (byte_i[7:2] == MOV_RM_TAG);
  assign last_disp  = (didx_q == IDX_W'(nb_q - 3'd1));

  movdec_dispsize u_size (
    .ab_i     (ab_in),
    .addr32_i (addr32_eff),
    .nbytes_o (nb_new),
    .sib_bad_o(sib_bad)
  );

  movdec_disp_acc #(.LANES(DISP_LANES)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (byte_valid_i && state_q == ST_DISP),
    .idx_i   (didx_q),
    .din_i   (byte_i),
    .nbytes_i(nb_q),
    .disp_o  (disp_ext)
  );

  movdec_len_ctr #(.W(LEN_W)) u_len (
    .clk   (clk),
    .rst   (rst),
    .clr_i (emit),
    .inc_i (byte_valid_i),
    .next_o(len_next)
  );

  always_comb begin
    emit    = 1'b0;
    unsup_n = 1'b0;
    if (byte_valid_i) begin
      case (state_q)
        ST_PREFIX: begin
          emit    = !is_pfx && !is_mov;
          unsup_n = 1'b1;
        end
        ST_MODRM: begin
          emit    = sib_bad || (nb_new == 3'd0);
          unsup_n = sib_bad;
        end
        default: emit = last_disp;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_PREFIX;
      opsz_q  <= 1'b0;
      adsz_q  <= 1'b0;
      dir_q   <= 1'b0;
      wide_q  <= 1'b0;
      ab_q    <= '0;
      nb_q    <= '0;
      didx_q  <= '0;
    end else if (byte_valid_i) begin
      if (emit) begin
        state_q <= ST_PREFIX;
        opsz_q  <= 1'b0;
        adsz_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_PREFIX: begin
            if (byte_i == PFX_OPSZ)      opsz_q <= 1'b1;
            else if (byte_i == PFX_ADSZ) adsz_q <= 1'b1;
            else begin
              dir_q   <= byte_i[1];
              wide_q  <= byte_i[0];
              state_q <= ST_MODRM;
            end
          end
          ST_MODRM: begin
            ab_q    <= ab_in;
            nb_q    <= nb_new;
            didx_q  <= '0;
            state_q <= ST_DISP;
          end
          default: didx_q <= didx_q + 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid_o <= 1'b0;
      unsup_o     <= 1'b0;
      op32_o      <= 1'b0;
      addr32_o    <= 1'b0;
      dir_o       <= 1'b0;
      wide_o      <= 1'b0;
      opnd_bits_o <= '0;
      mod_o       <= '0;
      reg_o       <= '0;
      rm_o        <= '0;
      disp_o      <= '0;
      len_o       <= '0;
    end else begin
      rec_valid_o <= emit;
      if (emit) begin
        unsup_o  <= unsup_n;
        op32_o   <= op32_eff;
        addr32_o <= addr32_eff;
        len_o    <= len_next;
        if (unsup_n) begin
          dir_o       <= 1'b0;
          wide_o      <= 1'b0;
          opnd_bits_o <= '0;
          mod_o       <= '0;
          reg_o       <= '0;
          rm_o        <= '0;
          disp_o      <= '0;
        end else begin
          dir_o       <= dir_q;
          wide_o      <= wide_q;
          opnd_bits_o <= !wide_q ? 6'd8 : (op32_eff ? 6'd32 : 6'd16);
          if (state_q == ST_MODRM) begin
            mod_o  <= ab_in.mode;
            reg_o  <= ab_in.regf;
            rm_o   <= ab_in.rmf;
            disp_o <= '0;
          end else begin
            mod_o  <= ab_q.mode;
            reg_o  <= ab_q.regf;
            rm_o   <= ab_q.rmf;
            disp_o <= disp_ext;
          end
        end
      end
    end
  end
endmodule

// File: rtl/movdec_checker.sv
module movdec_checker #(
  parameter int LEN_W = 4,
  parameter int DISP_LANES = 4,
  localparam int DW = 8 * DISP_LANES
) (
  input logic             clk,
  input logic             rst,
  input logic             mode32_i,
  input logic             byte_valid_i,
  input logic [7:0]       byte_i,
  input logic             rec_valid_o,
  input logic             unsup_o,
  input logic             op32_o,
  input logic             addr32_o,
  input logic             dir_o,
  input logic             wide_o,
  input logic [5:0]       opnd_bits_o,
  input logic [1:0]       mod_o,
  input logic [2:0]       reg_o,
  input logic [2:0]       rm_o,
  input logic [DW-1:0]    disp_o,
  input logic [LEN_W-1:0] len_o
);
  assert_rec_follows_byte_R10: assert property (@(posedge clk) disable iff (rst)
    rec_valid_o |-> $past(byte_valid_i));

  assert_fields_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rec_valid_o |-> ($stable(len_o) && $stable(disp_o) && $stable(unsup_o)));

  assert_byte_width_R3: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && !unsup_o && !wide_o) |-> (opnd_bits_o == 6'd8));

  assert_wide_width_R3: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && !unsup_o && wide_o) |-> (opnd_bits_o == (op32_o ? 6'd32 : 6'd16)));

  assert_reg_mode_no_disp_R6: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && !unsup_o && mod_o == 2'b11) |-> (disp_o == '0));

  assert_disp8_sext_R6: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && !unsup_o && mod_o == 2'b01) |->
      (disp_o[DW-1:7] == '0 || disp_o[DW-1:7] == '1));

  assert_min_length_R7: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && !unsup_o) |-> (len_o >= LEN_W'(2)));
endmodule

bind movdec_top movdec_checker #(.LEN_W(LEN_W), .DISP_LANES(DISP_LANES)) chk_i (.*);

// File: tb/movdec_top_tb_top.sv
module movdec_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode32_i = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        rec_valid_o, unsup_o, op32_o, addr32_o, dir_o, wide_o;
  logic [5:0]  opnd_bits_o;
  logic [1:0]  mod_o;
  logic [2:0]  reg_o, rm_o;
  logic [31:0] disp_o;
  logic [3:0]  len_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  in_instr = 1'b0;
  logic [7:0] pat = 8'h13;

  always #2 clk = ~clk;

  movdec_top dut_i (
    .clk(clk), .rst(rst), .mode32_i(mode32_i), .byte_valid_i(byte_valid_i),
    .byte_i(byte_i), .rec_valid_o(rec_valid_o), .unsup_o(unsup_o),
    .op32_o(op32_o), .addr32_o(addr32_o), .dir_o(dir_o), .wide_o(wide_o),
    .opnd_bits_o(opnd_bits_o), .mod_o(mod_o), .reg_o(reg_o), .rm_o(rm_o),
    .disp_o(disp_o), .len_o(len_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    if (in_instr) chk("R5 no record before final byte", 64'(rec_valid_o), 64'd0);
    byte_valid_i = 1'b1;
    byte_i = b;
    in_instr = 1'b1;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    byte_valid_i = 1'b0;
    byte_i = 8'h66;
    @(posedge clk);
  endtask

  task automatic expect_rec(input string utag, input bit e_unsup, input bit e_o32,
                            input bit e_a32, input bit e_dir, input bit e_wide,
                            input logic [5:0] e_bits, input logic [1:0] e_mod,
                            input logic [2:0] e_reg, input logic [2:0] e_rm,
                            input logic [31:0] e_disp, input int e_len);
    int sat;
    sat = (e_len > 15) ? 15 : e_len;
    @(negedge clk);
    byte_valid_i = 1'b0;
    chk("R10 record strobe", 64'(rec_valid_o), 64'd1);
    chk(utag, 64'(unsup_o), 64'(e_unsup));
    chk("R2 operand size", 64'(op32_o), 64'(e_o32));
    chk("R2 address size", 64'(addr32_o), 64'(e_a32));
    chk("R3 direction", 64'(dir_o), 64'(e_dir));
    chk("R3 width bit", 64'(wide_o), 64'(e_wide));
    chk("R3 operand bits", 64'(opnd_bits_o), 64'(e_bits));
    chk("R4 mode field", 64'(mod_o), 64'(e_mod));
    chk("R4 reg field", 64'(reg_o), 64'(e_reg));
    chk("R4 rm field", 64'(rm_o), 64'(e_rm));
    chk("R6 displacement", 64'(disp_o), 64'(e_disp));
    chk("R7 length", 64'(len_o), 64'(sat));
    @(negedge clk);
    chk("R10 single-cycle strobe", 64'(rec_valid_o), 64'd0);
    chk("R10 fields hold", 64'(len_o), 64'(sat));
    in_instr = 1'b0;
  endtask

  task automatic run_mov(input bit m, input int p6, input int p7, input int op,
                         input int md, input int rm, input int rg, input bit gap);
    bit a32, o32, sib;
    int n;
    logic [7:0] db [4];
    logic [31:0] ed;
    logic [5:0] bits;
    a32 = m ^ (p7 > 0);
    o32 = m ^ (p6 > 0);
    sib = a32 && md != 3 && rm == 4;
    if (md == 3) n = 0;
    else if (md == 1) n = 1;
    else if (md == 2) n = a32 ? 4 : 2;
    else n = a32 ? ((rm == 5) ? 4 : 0) : ((rm == 6) ? 2 : 0);
    mode32_i = m;
    if (rm[0]) begin
      for (int i = 0; i < p7; i++) put(8'h67);
      for (int i = 0; i < p6; i++) put(8'h66);
    end else begin
      for (int i = 0; i < p6; i++) put(8'h66);
      for (int i = 0; i < p7; i++) put(8'h67);
    end
    put(8'h88 + 8'(op));
    if (gap) idle();
    put({2'(md), 3'(rg), 3'(rm)});
    if (sib) begin
      expect_rec("R9 scale-index unsupported", 1'b1, o32, a32, 1'b0, 1'b0, 6'd0,
                 2'd0, 3'd0, 3'd0, 32'd0, p6 + p7 + 2);
    end else begin
      for (int k = 0; k < 4; k++) db[k] = 8'h00;
      for (int k = 0; k < n; k++) begin
        pat = pat + 8'h47;
        db[k] = pat;
        if (gap && k == 1) idle();
        put(pat);
      end
      if (n == 1) ed = {{24{db[0][7]}}, db[0]};
      else if (n == 2) ed = {{16{db[1][7]}}, db[1], db[0]};
      else if (n == 4) ed = {db[3], db[2], db[1], db[0]};
      else ed = 32'd0;
      bits = (op % 2 == 0) ? 6'd8 : (o32 ? 6'd32 : 6'd16);
      expect_rec("R8 supported opcode", 1'b0, o32, a32, op[1], op[0], bits,
                 2'(md), 3'(rg), 3'(rm), ed, p6 + p7 + 2 + n);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset strobe", 64'(rec_valid_o), 64'd0);
    chk("R1 reset length", 64'(len_o), 64'd0);
    chk("R1 reset disp", 64'(disp_o), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 strobe after reset", 64'(rec_valid_o), 64'd0);
    chk("R1 fields after reset", 64'({unsup_o, op32_o, addr32_o, dir_o, wide_o,
        opnd_bits_o, mod_o, reg_o, rm_o}), 64'd0);

    for (int m = 0; m < 2; m++)
      for (int p6 = 0; p6 < 3; p6++)
        for (int p7 = 0; p7 < 2; p7++)
          for (int op = 0; op < 4; op++)
            for (int md = 0; md < 4; md++)
              for (int rm = 0; rm < 8; rm++)
                run_mov(m[0], p6, p7, op, md, rm, (rm + md + op) % 8, (rm == 3));

    for (int b = 0; b < 256; b++) begin
      if (b != 8'h66 && b != 8'h67 && (b < 8'h88 || b > 8'h8B)) begin
        bit m, pf;
        m = b[0];
        pf = b[1];
        mode32_i = m;
        if (pf) put(8'h66);
        put(8'(b));
        expect_rec("R8 unsupported opcode", 1'b1, m ^ pf, m, 1'b0, 1'b0, 6'd0,
                   2'd0, 3'd0, 3'd0, 32'd0, pf ? 2 : 1);
      end
    end

    mode32_i = 1'b0;
    for (int i = 0; i < 14; i++) put(8'h66);
    put(8'h8B);
    put(8'h80);
    put(8'h34);
    put(8'h92);
    expect_rec("R7 saturation", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd32,
               2'd2, 3'd0, 3'd0, 32'hFFFF9234, 18);

    run_mov(1'b0, 0, 0, 1, 2, 0, 5, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule